// File: doc/BRIEF.md
# Static Direction Branch Predictor

This block sits beside the fetch stage and picks the next fetch address for every instruction in the same cycle that the instruction arrives. It keeps no history. A conditional branch whose displacement is negative is guessed taken, because it most likely closes a loop. A conditional branch with a zero or positive displacement is guessed not taken. An unconditional jump always sends fetch to its target, and any other instruction falls through to the next word.

Each conditional branch that is fetched gets a small tag. While the branch is outstanding the block keeps both its fall-through address and its target. When the execute stage reports the branch's real outcome under that tag, the block compares the outcome with the guess. If they differ, it raises a flush in that same cycle, supplies the address that was not chosen, and discards every branch fetched after the wrong one.

Top module: `static_dir_predictor`

## Requirements
- R1: After reset no branch is outstanding, `flush` and `fetch_stall` are low, and the first conditional branch accepted receives tag 0.
- R2: When `fetch_valid` is high and the opcode `fetch_insn[31:26]` is neither 6'h10 (conditional branch) nor 6'h12 (jump), `next_pc` equals `fetch_pc + 4`, `pred_taken` is 0 and no tag is allocated.
- R3: A conditional branch (opcode 6'h10) whose 16-bit signed word displacement `fetch_insn[15:0]` is negative is predicted taken. `next_pc` equals `fetch_pc + (sign-extended displacement << 2)`, with the sum wrapping modulo 2^32.
- R4: A conditional branch whose displacement is zero or positive is predicted not taken: `next_pc = fetch_pc + 4` and `pred_taken` is 0.
- R5: A jump (opcode 6'h12) always redirects. `pred_taken` is 1, `next_pc = fetch_pc + (sign-extended fetch_insn[25:0] << 2)`, and no tag is allocated.
- R6: Each accepted conditional branch raises `br_alloc` and gets tag `br_tag`. Tags are handed out in sequence modulo 4, so up to four branches can be outstanding.
- R7: When the next tag in sequence is still outstanding, a valid conditional branch is refused. `fetch_stall` is 1, `br_alloc` is 0, `pred_taken` is 0 and `next_pc` equals `fetch_pc`.
- R8: A resolution (`res_valid`, `res_tag`, `res_taken`) that agrees with the prediction for an outstanding tag raises no flush and frees that tag.
- R9: A resolution that disagrees with the prediction for an outstanding tag raises `flush` in the same cycle. `redirect_pc` is the target when `res_taken` is 1 and the fall-through address when it is 0.
- R10: On a flush, the resolved branch and all branches fetched after it are discarded. No branch is accepted in that cycle, and the next tag handed out is the resolved tag plus 1. A later resolution of a discarded tag raises no flush.
- R11: A resolution for a tag that is not outstanding raises no flush and changes nothing.
- R12: While `fetch_valid` is low, `br_alloc` and `fetch_stall` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetched instruction is present |
| fetch_pc | input | 32 | Address of the fetched instruction |
| fetch_insn | input | 32 | Fetched instruction word |
| res_valid | input | 1 | A branch outcome is reported |
| res_tag | input | 2 | Tag of the branch being resolved |
| res_taken | input | 1 | Actual direction of the resolved branch |
| next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Fetch is redirected away from the sequential path |
| br_alloc | output | 1 | A conditional branch was accepted and tagged |
| br_tag | output | 2 | Tag given to the accepted branch |
| fetch_stall | output | 1 | Conditional branch refused, no free tag |
| flush | output | 1 | Misprediction, discard younger work |
| redirect_pc | output | 32 | Corrected fetch address while flush is high |

## Verification
The bound checker watches, on every cycle, the rules that relate the ports at a single moment or across adjacent cycles. These are sequential fall-through for plain instructions, jumps always redirecting without a tag, the stall holding the PC, the silence of an idle fetch, flush only coming with a resolution and blocking allocation, tags advancing by one across back-to-back allocations, and a flushed tag never flushing again in the next cycle. Some behaviours need a history of stimulus, and only the bench's scenarios can show them: the exact target arithmetic including wrap-around, the choice of alternate address on a wrong guess, the discarding of younger branches, the tag counter rewinding after a flush, and the refusal of a fifth branch when four are outstanding.

// File: rtl/bp_pkg.sv
// Package: shared encodings for the static direction predictor.
// Assumes the major opcode sits in the six most significant instruction bits.
package bp_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_COND_BR = 6'h10;
    localparam logic [OPC_W-1:0] OPC_JUMP    = 6'h12;

    // Instruction class as seen by the predictor.
    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_COND  = 2'd1,
        KIND_JUMP  = 2'd2
    } bp_kind_e;

endpackage

// File: rtl/bp_decode.sv
// Module: bp_decode
// Classifies a fetched word and computes the fall-through and both candidate
// targets. It is purely combinational. It assumes word-aligned PCs and
// displacements counted in 4-byte words.
module bp_decode #(
    parameter int ADDR_W     = 32,
    parameter int INSN_W     = 32,
    parameter int BR_DISP_W  = 16,
    parameter int JMP_DISP_W = 26
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [INSN_W-1:0] insn,
    output bp_pkg::bp_kind_e  kind,
    output logic              backward,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] br_tgt,
    output logic [ADDR_W-1:0] jmp_tgt
);
    import bp_pkg::*;

    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int BR_PAD  = ADDR_W - BR_DISP_W - 2;
    localparam int JMP_PAD = ADDR_W - JMP_DISP_W - 2;

    logic [OPC_W-1:0]  opcode;
    logic [ADDR_W-1:0] br_off;
    logic [ADDR_W-1:0] jmp_off;

    // Pick out the opcode field.
    assign opcode = insn[INSN_W-1:OPC_LSB];

    // Map the opcode onto an instruction class.
    always_comb begin
        case (opcode)
            OPC_COND_BR: kind = KIND_COND;
            OPC_JUMP:    kind = KIND_JUMP;
            default:     kind = KIND_PLAIN;
        endcase
    end

    // Sign-extend the word displacements and turn them into byte offsets.
    assign br_off  = {{BR_PAD{insn[BR_DISP_W-1]}},   insn[BR_DISP_W-1:0],  2'b00};
    assign jmp_off = {{JMP_PAD{insn[JMP_DISP_W-1]}}, insn[JMP_DISP_W-1:0], 2'b00};

    // Candidate addresses; every sum wraps modulo 2^ADDR_W.
    assign fall_pc  = pc + ADDR_W'(4);
    assign br_tgt   = pc + br_off;
    assign jmp_tgt  = pc + jmp_off;
    assign backward = insn[BR_DISP_W-1];

endmodule

// File: rtl/bp_direction.sv
// Module: bp_direction
// Applies the static policy: a backward conditional branch goes to its target,
// a forward one falls through, and a jump always redirects. A conditional branch
// that cannot get a tag holds fetch at the same PC. It is combinational.
module bp_direction #(
    parameter int ADDR_W = 32
) (
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  bp_pkg::bp_kind_e  kind,
    input  logic              backward,
    input  logic [ADDR_W-1:0] fall_pc,
    input  logic [ADDR_W-1:0] br_tgt,
    input  logic [ADDR_W-1:0] jmp_tgt,
    input  logic              slot_busy,
    output logic              stall,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] next_pc
);
    import bp_pkg::*;

    // Refuse a conditional branch when its tag slot is still in use.
    assign stall = fetch_valid && (kind == KIND_COND) && slot_busy;

    // Choose the next fetch address and the redirect flag.
    always_comb begin
        next_pc    = fall_pc;
        pred_taken = 1'b0;
        if (fetch_valid) begin
            if (stall) begin
                next_pc = fetch_pc;
            end else if (kind == KIND_JUMP) begin
                next_pc    = jmp_tgt;
                pred_taken = 1'b1;
            end else if (kind == KIND_COND && backward) begin
                next_pc    = br_tgt;
                pred_taken = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bp_inflight.sv
// Module: bp_inflight
// Tracks the conditional branches that are still outstanding. Tags are issued in
// a ring. Each entry holds the predicted direction and both addresses. A
// resolution frees its entry. A wrong guess flushes, discards the younger
// entries and rewinds the ring. It assumes alloc_req is low whenever slot_busy
// or flush is high.
module bp_inflight #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              alloc_pred,
    input  logic [ADDR_W-1:0] alloc_fall,
    input  logic [ADDR_W-1:0] alloc_tgt,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic              res_taken,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              slot_busy,
    output logic              flush,
    output logic [ADDR_W-1:0] redirect_pc
);
    localparam int DEPTH = 1 << TAG_W;

    logic [DEPTH-1:0]  valid_q, valid_d;
    logic [DEPTH-1:0]  pred_q;
    logic [DEPTH-1:0]  younger;
    logic [ADDR_W-1:0] fall_q [DEPTH];
    logic [ADDR_W-1:0] tgt_q  [DEPTH];
    logic [TAG_W-1:0]  tail_q;
    logic [TAG_W-1:0]  dist_tail;
    logic              res_hit;

    // A resolution only counts for a tag that is outstanding.
    assign res_hit = res_valid && valid_q[res_tag];

    // A wrong guess flushes and redirects to the address that was not chosen.
    assign flush       = res_hit && (res_taken != pred_q[res_tag]);
    assign redirect_pc = res_taken ? tgt_q[res_tag] : fall_q[res_tag];

    // The next tag to hand out and whether its slot is free.
    assign alloc_tag = tail_q;
    assign slot_busy = valid_q[tail_q];

    // Ring distance from the resolved tag to the next free position.
    assign dist_tail = tail_q - res_tag;

    // Mark every valid entry that was issued after the resolved one.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_age
        logic [TAG_W-1:0] dist_i;
        assign dist_i = TAG_W'(gi) - res_tag;
        assign younger[gi] = valid_q[gi] && (dist_i != '0) &&
                             ((dist_tail == '0) || (dist_i < dist_tail));
    end

    // Work out the next occupancy from the flush, the free and the allocation.
    always_comb begin
        valid_d = valid_q;
        if (flush) begin
            valid_d = valid_q & ~younger & ~(DEPTH'(1) << res_tag);
        end else begin
            if (res_hit)   valid_d[res_tag] = 1'b0;
            if (alloc_req) valid_d[tail_q]  = 1'b1;
        end
    end

    // Occupancy and ring pointer, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tail_q  <= '0;
        end else begin
            valid_q <= valid_d;
            if (flush)          tail_q <= res_tag + TAG_W'(1);
            else if (alloc_req) tail_q <= tail_q + TAG_W'(1);
        end
    end

    // Entry payload, written only on allocation; valid_q guards its use.
    always_ff @(posedge clk) begin
        if (alloc_req) begin
            pred_q[tail_q] <= alloc_pred;
            fall_q[tail_q] <= alloc_fall;
            tgt_q[tail_q]  <= alloc_tgt;
        end
    end

endmodule

// File: rtl/static_dir_predictor.sv
// Module: static_dir_predictor
// Top of the static direction predictor. It decodes the fetched word, picks the
// next PC from the sign of the displacement, tags conditional branches and
// raises a flush when a resolved outcome disputes the guess. It assumes the
// fetch unit gives priority to flush over next_pc in the same cycle.
module static_dir_predictor #(
    parameter int ADDR_W     = 32,
    parameter int INSN_W     = 32,
    parameter int BR_DISP_W  = 16,
    parameter int JMP_DISP_W = 26,
    parameter int TAG_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [INSN_W-1:0] fetch_insn,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic              res_taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_taken,
    output logic              br_alloc,
    output logic [TAG_W-1:0]  br_tag,
    output logic              fetch_stall,
    output logic              flush,
    output logic [ADDR_W-1:0] redirect_pc
);
    import bp_pkg::*;

    bp_kind_e          kind;
    logic              backward;
    logic [ADDR_W-1:0] fall_pc, br_tgt, jmp_tgt;
    logic              slot_busy;
    logic              alloc_req;

    bp_decode #(
        .ADDR_W(ADDR_W), .INSN_W(INSN_W),
        .BR_DISP_W(BR_DISP_W), .JMP_DISP_W(JMP_DISP_W)
    ) u_decode (
        .pc(fetch_pc), .insn(fetch_insn), .kind(kind), .backward(backward),
        .fall_pc(fall_pc), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt)
    );

    bp_direction #(.ADDR_W(ADDR_W)) u_direction (
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .kind(kind),
        .backward(backward), .fall_pc(fall_pc), .br_tgt(br_tgt),
        .jmp_tgt(jmp_tgt), .slot_busy(slot_busy), .stall(fetch_stall),
        .pred_taken(pred_taken), .next_pc(next_pc)
    );

    // Accept a conditional branch only when a tag is free and no flush is under way.
    assign alloc_req = fetch_valid && (kind == KIND_COND) && !slot_busy && !flush;
    assign br_alloc  = alloc_req;

    bp_inflight #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_inflight (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_pred(backward),
        .alloc_fall(fall_pc), .alloc_tgt(br_tgt), .res_valid(res_valid),
        .res_tag(res_tag), .res_taken(res_taken), .alloc_tag(br_tag),
        .slot_busy(slot_busy), .flush(flush), .redirect_pc(redirect_pc)
    );

endmodule

// File: rtl/static_dir_predictor_checker.sv
// Module: static_dir_predictor_checker
// Port-level rules of the predictor, checked on every clock. It is bound into
// every static_dir_predictor instance.
module static_dir_predictor_checker #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32,
    parameter int TAG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [INSN_W-1:0] fetch_insn,
    input logic              res_valid,
    input logic [TAG_W-1:0]  res_tag,
    input logic [ADDR_W-1:0] next_pc,
    input logic              pred_taken,
    input logic              br_alloc,
    input logic [TAG_W-1:0]  br_tag,
    input logic              fetch_stall,
    input logic              flush
);
    import bp_pkg::*;

    logic [OPC_W-1:0] opc;
    assign opc = fetch_insn[INSN_W-1:INSN_W-OPC_W];

    p_plain_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && opc != OPC_COND_BR && opc != OPC_JUMP)
        |-> (next_pc == fetch_pc + ADDR_W'(4) && !pred_taken && !br_alloc));

    p_jump_redirects_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && opc == OPC_JUMP) |-> (pred_taken && !br_alloc));

    p_tag_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_alloc && !flush) |=> (br_alloc |-> br_tag == $past(br_tag) + TAG_W'(1)));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (next_pc == fetch_pc && !pred_taken && !br_alloc));

    p_flush_needs_res_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> res_valid);

    p_flush_blocks_alloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !br_alloc);

    p_flushed_tag_gone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !(flush && res_tag == $past(res_tag)));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (!br_alloc && !fetch_stall));

endmodule

bind static_dir_predictor static_dir_predictor_checker #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .TAG_W(TAG_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_insn(fetch_insn), .res_valid(res_valid), .res_tag(res_tag),
    .next_pc(next_pc), .pred_taken(pred_taken), .br_alloc(br_alloc),
    .br_tag(br_tag), .fetch_stall(fetch_stall), .flush(flush)
);

// File: tb/static_dir_predictor_tb_top.sv
module static_dir_predictor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // Vector table: pc, insn, expected next pc, taken, alloc, requirement.
    localparam logic [31:0] V_PC [NV] = '{
        32'h0000_1000, 32'h0000_1000, 32'h0000_2000, 32'h0000_2000, 32'h0000_3000,
        32'h0000_4000, 32'h0000_4000, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_5000};
    localparam logic [31:0] V_INSN [NV] = '{
        32'h0000_0000, 32'h4000_FFFC, 32'h4000_0010, 32'h4000_0000, 32'h4000_8000,
        32'h4800_0100, 32'h4BFF_FFFF, 32'hFC00_0000, 32'h4000_7FFF, 32'h4400_0000};
    localparam logic [31:0] V_NEXT [NV] = '{
        32'h0000_1004, 32'h0000_0FF0, 32'h0000_2004, 32'h0000_2004, 32'hFFFE_3000,
        32'h0000_4400, 32'h0000_3FFC, 32'h0000_0000, 32'h0000_0004, 32'h0000_5004};
    localparam logic V_TAKEN [NV] = '{0, 1, 0, 0, 1, 1, 1, 0, 0, 0};
    localparam logic V_ALLOC [NV] = '{0, 1, 1, 1, 1, 0, 0, 0, 1, 0};
    localparam int   V_REQ   [NV] = '{2, 3, 4, 4, 3, 5, 5, 2, 4, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] fetch_insn = '0;
    logic        res_valid = 1'b0;
    logic [1:0]  res_tag = '0;
    logic        res_taken = 1'b0;
    logic [31:0] next_pc, redirect_pc;
    logic        pred_taken, br_alloc, fetch_stall, flush;
    logic [1:0]  br_tag;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    static_dir_predictor dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_insn(fetch_insn), .res_valid(res_valid), .res_tag(res_tag),
        .res_taken(res_taken), .next_pc(next_pc), .pred_taken(pred_taken),
        .br_alloc(br_alloc), .br_tag(br_tag), .fetch_stall(fetch_stall),
        .flush(flush), .redirect_pc(redirect_pc));

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string req_name(input int r);
        case (r)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus after the falling edge, then let outputs settle.
    task automatic apply(input logic fv, input logic [31:0] pc, input logic [31:0] insn,
                         input logic rv, input logic [1:0] rt, input logic rk);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; fetch_insn = insn;
        res_valid = rv; res_tag = rt; res_taken = rk;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fetch_valid = 1'b0; res_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] t;
        do_reset();

        // R1: idle state straight after reset.
        apply(0, 32'h0, 32'h0, 0, 0, 0);
        chk("R1 flush", flush, 0);
        chk("R1 stall", fetch_stall, 0);
        chk("R12 idle alloc", br_alloc, 0);

        // Table walk; every accepted branch is resolved as guessed (R8).
        for (int i = 0; i < NV; i++) begin
            apply(1, V_PC[i], V_INSN[i], 0, 0, 0);
            chk(req_name(V_REQ[i]), next_pc, V_NEXT[i]);
            chk(req_name(V_REQ[i]), pred_taken, V_TAKEN[i]);
            chk("R6 alloc", br_alloc, V_ALLOC[i]);
            t = br_tag;
            if (V_ALLOC[i]) begin
                apply(0, 32'h0, 32'h0, 1, t, V_TAKEN[i]);
                chk("R8 agree no flush", flush, 0);
            end
        end

        // R1 and R6: tags from reset, then R7 when the ring is full.
        do_reset();
        for (int k = 0; k < 4; k++) begin
            apply(1, 32'h100 + 32'(k * 16), 32'h4000_0004, 0, 0, 0);
            chk("R6 alloc", br_alloc, 1);
            chk(k == 0 ? "R1 first tag" : "R6 tag", br_tag, k);
        end
        apply(1, 32'h180, 32'h4000_FFF0, 0, 0, 0);
        chk("R7 stall", fetch_stall, 1);
        chk("R7 no alloc", br_alloc, 0);
        chk("R7 hold pc", next_pc, 32'h180);
        chk("R7 no redirect", pred_taken, 0);
        apply(0, 32'h0, 32'h0, 1, 0, 0);
        chk("R8 agree no flush", flush, 0);
        apply(1, 32'h190, 32'h4000_0004, 0, 0, 0);
        chk("R6 wrap alloc", br_alloc, 1);
        chk("R6 wrap tag", br_tag, 0);

        // R9 and R10: wrong guesses, discarding and ring rewind.
        do_reset();
        apply(1, 32'h200, 32'h4000_0008, 0, 0, 0);   // tag 0, not taken, target 0x220
        apply(1, 32'h300, 32'h4000_FFFE, 0, 0, 0);   // tag 1, taken, fall 0x304
        apply(1, 32'h400, 32'h4000_0001, 0, 0, 0);   // tag 2
        chk("R6 third tag", br_tag, 2);
        apply(1, 32'h500, 32'h4000_0004, 1, 1, 0);
        chk("R9 flush", flush, 1);
        chk("R9 redirect fall", redirect_pc, 32'h304);
        chk("R10 no alloc in flush", br_alloc, 0);
        apply(1, 32'h600, 32'h4000_0004, 1, 2, 1);
        chk("R10 dropped tag no flush", flush, 0);
        chk("R10 rewound tag", br_tag, 2);
        chk("R10 alloc after flush", br_alloc, 1);
        apply(0, 32'h0, 32'h0, 1, 0, 1);
        chk("R9 flush taken", flush, 1);
        chk("R9 redirect target", redirect_pc, 32'h220);
        apply(1, 32'h700, 32'h4000_0004, 0, 0, 0);
        chk("R10 rewound tag", br_tag, 1);
        apply(0, 32'h0, 32'h0, 1, 2, 0);
        chk("R10 younger gone", flush, 0);
        apply(0, 32'h0, 32'h0, 1, 3, 1);
        chk("R11 stale tag", flush, 0);
        apply(0, 32'h800, 32'h4000_FFF0, 0, 0, 0);
        chk("R12 idle alloc", br_alloc, 0);
        chk("R12 idle stall", fetch_stall, 0);
        apply(1, 32'h900, 32'h4000_0004, 0, 0, 0);
        chk("R11 ring unchanged", br_tag, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule